// File: doc/BRIEF.md
# Two-Input Pixel Layer Blender

This block merges two pixel streams, a primary layer and a secondary layer, into a single output stream. For every output pixel it scales the primary pixel and the secondary pixel by a weight each, adds the two, and normalises the sum back to eight bits. Each weight is picked by a 3-bit code from a set of eight: zero, one, either layer's alpha, a programmable constant alpha, and the complement of each of those three alphas. Colour and alpha have separate codes, so four codes are in use at once. A mode bit bypasses the arithmetic and forwards the primary pixel unchanged.

The secondary layer is visible only from a programmable X/Y offset onward. Pixel coordinates come from counting primary pixels: start-of-frame and end-of-line markers reset and advance the counters. Configuration is written through a plain register port into a pending set. When shadowing is on, the pending set moves into the active set only when a start-of-frame pixel pair is accepted, so a frame is never blended with a mix of old and new settings.

Both inputs and the output are valid/ready streams. A primary pixel and a secondary pixel are always taken together as a pair. Each input's ready is asserted only when the other input is also valid and the pipeline can advance. The pipeline has two register stages. It advances when the output is empty or is being taken, and when the output is held off every stage freezes at once.

Top module: `layer_blender`

## Requirements
- R1: After reset the output is not valid, mode is pass-through, shadowing is enabled, the blend word is 0x00FF0060 and the position is 0. The default blend word gives a primary colour code of 0, a secondary colour code of 6, alpha codes of 0 and a constant alpha of 0xFF, so in blend mode the output colour equals the secondary colour and the output alpha is 0.
- R2: In pass-through mode (control bit 0 = 0) the output pixel equals the primary pixel bit for bit.
- R3: A weight code maps to a value as follows: 0 gives 0, 1 gives 255, 2 gives the primary alpha, 3 gives 255 minus the primary alpha, 4 gives the secondary alpha, 5 gives 255 minus the secondary alpha, 6 gives the constant alpha, and 7 gives 255 minus the constant alpha. In the blend word (register 1), the primary colour code is bits 2:0, the secondary colour code is bits 6:4 and the constant alpha is bits 23:16.
- R4: The output alpha uses its own codes: the primary alpha code in bits 14:12 of the blend word and the secondary alpha code in bits 10:8. These are independent of the colour codes.
- R5: Each output byte is min(255, (P·wp + S·ws + 127) / 255) in integer arithmetic. A pixel holds NCH colour channels, with channel i in bits 8i+7:8i, and the alpha in the top byte.
- R6: A pixel at column x and row y lies inside the secondary window when x ≥ Xoff and y ≥ Yoff. Xoff is bits 15:0 and Yoff is bits 31:16 of register 2. Outside the window the secondary pixel is treated as zero colour and zero alpha. A pixel marked start-of-frame is at (0,0). The pixel after one marked end-of-line starts the next row at column 0.
- R7: With shadowing enabled (control bit 1 = 1), register writes do not change how pixels are blended until a pair marked start-of-frame is accepted. That pixel and the pixels after it use the new values.
- R8: With shadowing disabled, a register write applies to every pixel accepted from the cycle after the write.
- R9: A pair is accepted on a clock edge only when both inputs are valid and the pipeline can advance. Its output becomes valid after the second following clock edge.
- R10: While the output is valid and not ready, the output data and markers hold steady and neither input is ready.
- R11: The start-of-frame and end-of-line markers of the primary input leave with the same pixel at the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register index: 0 control, 1 blend word, 2 position |
| cfg_wdata | input | 32 | Register write data |
| p_valid | input | 1 | Primary pixel valid |
| p_ready | output | 1 | Primary pixel taken |
| p_data | input | 8·(NCH+1) | Primary pixel |
| p_sof | input | 1 | Primary start-of-frame marker |
| p_eol | input | 1 | Primary end-of-line marker |
| s_valid | input | 1 | Secondary pixel valid |
| s_ready | output | 1 | Secondary pixel taken |
| s_data | input | 8·(NCH+1) | Secondary pixel |
| o_valid | output | 1 | Output pixel valid |
| o_ready | input | 1 | Downstream accepts output |
| o_data | output | 8·(NCH+1) | Blended pixel |
| o_sof | output | 1 | Start-of-frame marker of the output pixel |
| o_eol | output | 1 | End-of-line marker of the output pixel |

## Verification
The bench runs every combination of primary and secondary weight code, with the alpha codes crossed against the colour codes. This exposes a swapped code, a missing complement, or colour and alpha sharing one selector. The chosen pixels push sums past 255 and leave fractional remainders, so a design that truncates or wraps instead of saturating produces a wrong byte. A small frame with an offset window checks every pixel's inside/outside status, which catches off-by-one errors in the coordinate compare and in row advance. Stall and shadow tests check that a held output keeps its data, and that a pending blend word is not applied before the start-of-frame pixel or is applied one pixel late.

// File: rtl/lb_pkg.sv
package lb_pkg;
  parameter int CW  = 8;
  parameter int XYW = 16;

  typedef struct packed {
    logic           mode;
    logic [CW-1:0]  calpha;
    logic [2:0]     sel_pa;
    logic [2:0]     sel_sa;
    logic [2:0]     sel_sc;
    logic [2:0]     sel_pc;
    logic [XYW-1:0] ypos;
    logic [XYW-1:0] xpos;
  } lb_cfg_t;

  localparam logic [CW-1:0] FULL = {CW{1'b1}};

  function automatic logic [CW-1:0] pick_weight(input logic [2:0] code,
                                                input logic [CW-1:0] pa,
                                                input logic [CW-1:0] sa,
                                                input logic [CW-1:0] ca);
    case (code)
      3'd0: pick_weight = '0;
      3'd1: pick_weight = FULL;
      3'd2: pick_weight = pa;
      3'd3: pick_weight = FULL - pa;
      3'd4: pick_weight = sa;
      3'd5: pick_weight = FULL - sa;
      3'd6: pick_weight = ca;
      default: pick_weight = FULL - ca;
    endcase
  endfunction
endpackage

// File: rtl/lb_shadow_cfg.sv
module lb_shadow_cfg
  import lb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  input  logic        frame_load,
  output lb_cfg_t     cfg_now
);
  lb_cfg_t pend_q, act_q, pend_d;
  logic    shd_en_q;
  logic    load_now;

  always_comb begin
    pend_d = pend_q;
    if (cfg_we) begin
      case (cfg_addr)
        2'd0: pend_d.mode = cfg_wdata[0];
        2'd1: begin
          pend_d.sel_pc = cfg_wdata[2:0];
          pend_d.sel_sc = cfg_wdata[6:4];
          pend_d.sel_sa = cfg_wdata[10:8];
          pend_d.sel_pa = cfg_wdata[14:12];
          pend_d.calpha = cfg_wdata[23:16];
        end
        2'd2: begin
          pend_d.xpos = cfg_wdata[XYW-1:0];
          pend_d.ypos = cfg_wdata[16+XYW-1:16];
        end
        default: ;
      endcase
    end
  end

  assign load_now = shd_en_q && frame_load;
  assign cfg_now  = load_now ? pend_q : act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q   <= '{mode: 1'b0, calpha: FULL, sel_pa: 3'd0, sel_sa: 3'd0,
                    sel_sc: 3'd6, sel_pc: 3'd0, ypos: '0, xpos: '0};
      act_q    <= '{mode: 1'b0, calpha: FULL, sel_pa: 3'd0, sel_sa: 3'd0,
                    sel_sc: 3'd6, sel_pc: 3'd0, ypos: '0, xpos: '0};
      shd_en_q <= 1'b1;
    end else begin
      pend_q <= pend_d;
      if (cfg_we && cfg_addr == 2'd0) shd_en_q <= cfg_wdata[1];
      if (!shd_en_q)     act_q <= pend_d;
      else if (load_now) act_q <= pend_q;
    end
  end

  AST_NO_MIDFRAME_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (shd_en_q && !frame_load) |=> $stable(act_q)); // R7
endmodule

// File: rtl/lb_pos_window.sv
module lb_pos_window
  import lb_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           acc,
  input  logic           sof,
  input  logic           eol,
  input  logic [XYW-1:0] xpos,
  input  logic [XYW-1:0] ypos,
  output logic           in_win
);
  logic [XYW-1:0] x_q, y_q, cur_x, cur_y;

  assign cur_x  = sof ? '0 : x_q;
  assign cur_y  = sof ? '0 : y_q;
  assign in_win = (cur_x >= xpos) && (cur_y >= ypos);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_q <= '0;
      y_q <= '0;
    end else if (acc) begin
      if (eol) begin
        x_q <= '0;
        y_q <= cur_y + 1'b1;
      end else begin
        x_q <= cur_x + 1'b1;
        y_q <= cur_y;
      end
    end
  end

  AST_ROW_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && eol) |=> (x_q == '0)); // R6
endmodule

// File: rtl/lb_blend_pipe.sv
module lb_blend_pipe
  import lb_pkg::*;
#(
  parameter int NCH = 3,
  localparam int PW = CW * (NCH + 1)
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc,
  input  logic [PW-1:0] p_data,
  input  logic [PW-1:0] s_data,
  input  logic          p_sof,
  input  logic          p_eol,
  input  logic          in_win,
  input  lb_cfg_t       cfg,
  input  logic          o_ready,
  output logic          adv,
  output logic          o_valid,
  output logic [PW-1:0] o_data,
  output logic          o_sof,
  output logic          o_eol
);
  localparam int SW = 2 * CW + 2;

  logic [PW-1:0] sec_eff;
  logic [CW-1:0] pa, sa;

  logic          s1_v, s1_mode, s1_sof, s1_eol;
  logic [PW-1:0] s1_prim, s1_sec;
  logic [CW-1:0] s1_wpc, s1_wsc, s1_wpa, s1_wsa;
  logic [PW-1:0] mix;

  assign adv     = !o_valid || o_ready;
  assign sec_eff = in_win ? s_data : '0;
  assign pa      = p_data[PW-1 -: CW];
  assign sa      = sec_eff[PW-1 -: CW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v    <= 1'b0;
      s1_mode <= 1'b0;
      s1_sof  <= 1'b0;
      s1_eol  <= 1'b0;
      s1_prim <= '0;
      s1_sec  <= '0;
      s1_wpc  <= '0;
      s1_wsc  <= '0;
      s1_wpa  <= '0;
      s1_wsa  <= '0;
    end else if (adv) begin
      s1_v <= acc;
      if (acc) begin
        s1_mode <= cfg.mode;
        s1_sof  <= p_sof;
        s1_eol  <= p_eol;
        s1_prim <= p_data;
        s1_sec  <= sec_eff;
        s1_wpc  <= pick_weight(cfg.sel_pc, pa, sa, cfg.calpha);
        s1_wsc  <= pick_weight(cfg.sel_sc, pa, sa, cfg.calpha);
        s1_wpa  <= pick_weight(cfg.sel_pa, pa, sa, cfg.calpha);
        s1_wsa  <= pick_weight(cfg.sel_sa, pa, sa, cfg.calpha);
      end
    end
  end

  for (genvar g = 0; g <= NCH; g++) begin : g_lane
    localparam bit IS_ALPHA = (g == NCH);
    logic [CW-1:0] wp, ws;
    logic [SW-1:0] sum;
    logic [SW-1:0] quo;
    assign wp  = IS_ALPHA ? s1_wpa : s1_wpc;
    assign ws  = IS_ALPHA ? s1_wsa : s1_wsc;
    assign sum = SW'(s1_prim[g*CW +: CW]) * SW'(wp)
               + SW'(s1_sec[g*CW +: CW]) * SW'(ws) + SW'(FULL >> 1);
    assign quo = sum / SW'(FULL);
    assign mix[g*CW +: CW] = (quo > SW'(FULL)) ? FULL : quo[CW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      o_valid <= 1'b0;
      o_data  <= '0;
      o_sof   <= 1'b0;
      o_eol   <= 1'b0;
    end else if (adv) begin
      o_valid <= s1_v;
      if (s1_v) begin
        o_data <= s1_mode ? mix : s1_prim;
        o_sof  <= s1_sof;
        o_eol  <= s1_eol;
      end
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && !o_ready) |=> (o_valid && $stable(o_data) && $stable(o_sof) && $stable(o_eol))); // R10
  AST_PASS_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && s1_v && !s1_mode) |=> (o_data == $past(s1_prim))); // R2
endmodule

// File: rtl/layer_blender.sv
module layer_blender
  import lb_pkg::*;
#(
  parameter int NCH = 3,
  localparam int PW = CW * (NCH + 1)
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_addr,
  input  logic [31:0]   cfg_wdata,
  input  logic          p_valid,
  output logic          p_ready,
  input  logic [PW-1:0] p_data,
  input  logic          p_sof,
  input  logic          p_eol,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [PW-1:0] s_data,
  output logic          o_valid,
  input  logic          o_ready,
  output logic [PW-1:0] o_data,
  output logic          o_sof,
  output logic          o_eol
);
  lb_cfg_t cfg_now;
  logic    adv, acc, in_win;

  assign p_ready = adv && s_valid;
  assign s_ready = adv && p_valid;
  assign acc     = p_valid && s_valid && adv;

  lb_shadow_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .frame_load(acc && p_sof), .cfg_now(cfg_now)
  );

  lb_pos_window u_win (
    .clk(clk), .rst_n(rst_n), .acc(acc), .sof(p_sof), .eol(p_eol),
    .xpos(cfg_now.xpos), .ypos(cfg_now.ypos), .in_win(in_win)
  );

  lb_blend_pipe #(.NCH(NCH)) u_pipe (
    .clk(clk), .rst_n(rst_n), .acc(acc), .p_data(p_data), .s_data(s_data),
    .p_sof(p_sof), .p_eol(p_eol), .in_win(in_win), .cfg(cfg_now),
    .o_ready(o_ready), .adv(adv), .o_valid(o_valid), .o_data(o_data),
    .o_sof(o_sof), .o_eol(o_eol)
  );

  AST_PAIR_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (p_valid && p_ready) == (s_valid && s_ready)); // R9
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && !o_ready) |-> (!p_ready && !s_ready)); // R10
endmodule

// File: tb/layer_blender_bench.sv
`timescale 1ns/1ps
module layer_blender_bench;
  localparam int NCH = 3;
  localparam int PW  = 8 * (NCH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic p_valid = 1'b0, s_valid = 1'b0, p_sof = 1'b0, p_eol = 1'b0, o_ready = 1'b1;
  logic [PW-1:0] p_data = '0, s_data = '0;
  logic p_ready, s_ready, o_valid, o_sof, o_eol;
  logic [PW-1:0] o_data;

  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  layer_blender #(.NCH(NCH)) u_layer_blender (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .p_valid(p_valid), .p_ready(p_ready),
    .p_data(p_data), .p_sof(p_sof), .p_eol(p_eol), .s_valid(s_valid),
    .s_ready(s_ready), .s_data(s_data), .o_valid(o_valid), .o_ready(o_ready),
    .o_data(o_data), .o_sof(o_sof), .o_eol(o_eol)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int wt(input int code, input int pa, input int sa, input int ca);
    case (code)
      0: return 0;       1: return 255;
      2: return pa;      3: return 255 - pa;
      4: return sa;      5: return 255 - sa;
      6: return ca;      default: return 255 - ca;
    endcase
  endfunction

  function automatic logic [PW-1:0] model(input logic [PW-1:0] p, input logic [PW-1:0] s,
                                          input int pc, input int sc, input int pac,
                                          input int sac, input int ca);
    logic [PW-1:0] r;
    int pa, sa;
    pa = p[PW-1 -: 8];
    sa = s[PW-1 -: 8];
    for (int g = 0; g <= NCH; g++) begin
      int wp, ws, v;
      wp = (g == NCH) ? wt(pac, pa, sa, ca) : wt(pc, pa, sa, ca);
      ws = (g == NCH) ? wt(sac, pa, sa, ca) : wt(sc, pa, sa, ca);
      v  = (int'(p[g*8 +: 8]) * wp + int'(s[g*8 +: 8]) * ws + 127) / 255;
      r[g*8 +: 8] = (v > 255) ? 8'hFF : v[7:0];
    end
    return r;
  endfunction

  function automatic logic [31:0] bword(input int pc, input int sc, input int pac,
                                        input int sac, input int ca);
    return {8'h00, ca[7:0], 1'b0, pac[2:0], 1'b0, sac[2:0], 1'b0, sc[2:0], 1'b0, pc[2:0]};
  endfunction

  task automatic wreg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // One pair, pipeline empty before; checks latency (R9) and returns output.
  task automatic xfer(input logic [PW-1:0] p, input logic [PW-1:0] s, input logic sof,
                      input logic eol, output logic [PW-1:0] od, output logic osof,
                      output logic oeol);
    @(negedge clk);
    p_valid = 1'b1; s_valid = 1'b1; p_data = p; s_data = s; p_sof = sof; p_eol = eol;
    @(negedge clk);
    p_valid = 1'b0; s_valid = 1'b0; p_sof = 1'b0; p_eol = 1'b0;
    check("R9 not yet valid after one edge", 64'(o_valid), 64'd0);
    @(negedge clk);
    check("R9 valid after two edges", 64'(o_valid), 64'd1);
    od = o_data; osof = o_sof; oeol = o_eol;
  endtask

  initial begin
    logic [PW-1:0] od, p, s, e;
    logic os, oe;
    fork
      begin
        repeat (150000) @(posedge clk);
        n_bad++; n_chk++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
      end
    join_none

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 output idle after reset", 64'(o_valid), 64'd0);
    p_valid = 1'b1; s_valid = 1'b0;
    #0.1 check("R9 p_ready needs s_valid", 64'(p_ready), 64'd0);
    p_valid = 1'b0;

    // R2: reset mode is pass-through
    xfer(32'h80_12_34_56, 32'hFF_AA_BB_CC, 1'b1, 1'b0, od, os, oe);
    check("R2 pass-through at reset", 64'(od), 64'h80123456);
    check("R11 sof carried", 64'(os), 64'd1);

    // R1: default blend word once blend mode is on, shadowing off
    wreg(2'd0, 32'h1);
    xfer(32'h80_12_34_56, 32'h40_AA_BB_CC, 1'b0, 1'b0, od, os, oe);
    check("R1 default blend gives secondary colour, zero alpha", 64'(od), 64'h00AABBCC);

    // R3/R4/R5/R8: sweep all colour codes, alpha codes crossed
    p = 32'hC8_F0_80_33;
    s = 32'h64_FF_40_01;
    for (int pc = 0; pc < 8; pc++) begin
      for (int sc = 0; sc < 8; sc++) begin
        wreg(2'd1, bword(pc, sc, sc, pc, 8'h5A));
        xfer(p, s, 1'b0, 1'b0, od, os, oe);
        e = model(p, s, pc, sc, sc, pc, 8'h5A);
        check("R3 R4 R5 R8 code sweep", 64'(od), 64'(e));
      end
    end

    // R6/R11: 4x3 frame, window from column 2, row 1, weights one/one
    wreg(2'd1, bword(1, 1, 1, 1, 8'hFF));
    wreg(2'd2, {16'd1, 16'd2});
    for (int y = 0; y < 3; y++) begin
      for (int x = 0; x < 4; x++) begin
        xfer(32'h20_10_10_10, 32'h07_05_05_05, (x == 0 && y == 0), (x == 3), od, os, oe);
        e = (x >= 2 && y >= 1) ? 32'h27_15_15_15 : 32'h20_10_10_10;
        check("R6 window membership", 64'(od), 64'(e));
        check("R11 eol carried", 64'(oe), 64'(x == 3));
      end
    end
    wreg(2'd2, 32'h0);

    // R10: back-pressure with pass-through mode
    wreg(2'd0, 32'h0);
    o_ready = 1'b0;
    p_valid = 1'b1; s_valid = 1'b1; p_data = 32'h11111111; s_data = '0;
    @(negedge clk); p_data = 32'h22222222;
    @(negedge clk); p_data = 32'h33333333;
    @(negedge clk);
    check("R10 input blocked during stall", 64'(p_ready || s_ready), 64'd0);
    check("R10 first pixel presented", 64'(o_data), 64'h11111111);
    repeat (3) @(negedge clk);
    check("R10 output held", 64'({o_valid, o_data}), {31'd0, 1'b1, 32'h11111111});
    o_ready = 1'b1;
    @(negedge clk);
    p_valid = 1'b0; s_valid = 1'b0;
    check("R10 second pixel after release", 64'(o_data), 64'h22222222);
    @(negedge clk);
    check("R10 third pixel in order", 64'(o_data), 64'h33333333);
    @(negedge clk);

    // R7: shadowed update waits for start-of-frame
    wreg(2'd0, 32'h1);
    wreg(2'd1, bword(1, 0, 1, 0, 8'hFF));
    wreg(2'd0, 32'h3);
    wreg(2'd1, bword(0, 1, 0, 1, 8'hFF));
    xfer(32'h90_01_02_03, 32'h30_0A_0B_0C, 1'b0, 1'b0, od, os, oe);
    check("R7 pending word not applied mid-frame", 64'(od), 64'h90010203);
    xfer(32'h90_01_02_03, 32'h30_0A_0B_0C, 1'b1, 1'b0, od, os, oe);
    check("R7 applied on start-of-frame pixel", 64'(od), 64'h300A0B0C);
    xfer(32'h90_01_02_03, 32'h30_0A_0B_0C, 1'b0, 1'b0, od, os, oe);
    check("R7 kept after load", 64'(od), 64'h300A0B0C);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule